// File: doc/BRIEF.md
# Load/Store Sub-Word Alignment Unit

This block sits between a 32-bit register datapath and a byte-addressed data memory that is 32 bits wide. For each memory instruction it receives the opcode, the base register value, a signed 16-bit displacement and, for stores, the source register value. It forms the effective address by adding the base to the sign-extended displacement. For stores it produces one write enable per byte lane and a write word with the data already moved into the addressed lanes. For loads it issues a read, takes the word the memory returns, picks out the addressed byte or halfword and extends it to 32 bits. Byte lanes are little-endian: lane k holds bits 8k+7..8k and sits at address offset k.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The load result is a valid/ready stream. `ld_valid` stays high and `ld_data` is held until the consumer raises `ld_ready`. While a load is in flight, or while a result is waiting to be taken, `req_ready` is low, so back-pressure on the result stalls the request side. The memory is synchronous. It must return `mem_rdata` in the cycle after `mem_re` is asserted.

Misaligned halfword and word accesses are flagged on `misalign` in the cycle they are taken. No memory access follows a flagged request.

Top module: `lsu_align_unit`

## Requirements
- R1: While `req_valid` is high, `mem_addr` equals `req_base` plus `req_disp` sign-extended to 32 bits, and this holds for positive and negative displacements.
- R2: After reset `req_ready` is high and `ld_valid` is low. `req_ready` is low in the cycle after a load is taken. It stays low while `ld_valid` is high and `ld_ready` is low. While `req_ready` is low, `mem_we` is 0 and `mem_re` is low.
- R3: A byte store (opcode 0x28) that is taken asserts exactly one bit of `mem_we`, bit `mem_addr[1:0]`. `mem_wdata` carries `req_wdata[7:0]` in that lane and zero in every other lane.
- R4: A halfword store (opcode 0x29) that is taken with `mem_addr[0]`=0 asserts `mem_we`=4'b0011 when `mem_addr[1]`=0 and 4'b1100 when it is 1. `req_wdata[15:0]` is placed in those lanes and the other lanes are zero.
- R5: A word store (opcode 0x2B) that is taken at an address that is a multiple of 4 asserts `mem_we`=4'b1111 with `mem_wdata` = `req_wdata`.
- R6: Signed byte and halfword loads (opcodes 0x20 and 0x21) return the addressed byte or halfword, sign-extended to 32 bits. A word load (opcode 0x23) returns the whole memory word.
- R7: Unsigned byte and halfword loads (opcodes 0x24 and 0x25) return the addressed byte or halfword, zero-extended to 32 bits.
- R8: A load that is taken asserts `mem_re` in its accept cycle. `ld_valid` goes high two cycles later with the extended result. While `ld_ready` is low, `ld_valid` and `ld_data` are held unchanged.
- R9: A halfword access with address bit 0 set, or a word access with either low address bit set, raises `misalign` in its accept cycle. It then drives `mem_we`=0 and `mem_re` low, and no load result follows.
- R10: Any other opcode is taken with no memory activity, no `misalign` and no load result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 6 | Memory instruction opcode |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register value |
| mem_addr | output | 32 | Effective byte address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Read word, valid the cycle after `mem_re` |
| misalign | output | 1 | Misaligned access taken this cycle |
| ld_valid | output | 1 | Load result valid |
| ld_ready | input | 1 | Consumer takes the load result |
| ld_data | output | 32 | Extended load result |

## Verification
A wrong lane offset or size in the pending-load register goes unseen until the result comes out. It shows up as a wrongly picked or wrongly extended `ld_data` two cycles after the `mem_re` pulse. A stuck in-flight or result-valid flag shows up at once as `req_ready` staying low, or as a missing or repeated `ld_valid`. Errors in address generation or lane steering are visible on `mem_addr`, `mem_we` and `mem_wdata` in the same cycle as the request. The stored bytes are also read back through later loads, which exposes corruption of lanes that should not have been touched.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  localparam int OP_W = 6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      is_load;
    logic      is_store;
    acc_size_e size;
    logic      sext;
  } acc_dec_t;

  localparam logic [OP_W-1:0] OPC_LDB  = 6'h20;
  localparam logic [OP_W-1:0] OPC_LDH  = 6'h21;
  localparam logic [OP_W-1:0] OPC_LDW  = 6'h23;
  localparam logic [OP_W-1:0] OPC_LDBU = 6'h24;
  localparam logic [OP_W-1:0] OPC_LDHU = 6'h25;
  localparam logic [OP_W-1:0] OPC_STB  = 6'h28;
  localparam logic [OP_W-1:0] OPC_STH  = 6'h29;
  localparam logic [OP_W-1:0] OPC_STW  = 6'h2B;

  function automatic acc_dec_t decode_op(input logic [OP_W-1:0] op);
    acc_dec_t d;
    d = '{is_load: 1'b0, is_store: 1'b0, size: SZ_BYTE, sext: 1'b0};
    case (op)
      OPC_LDB:  d = '{1'b1, 1'b0, SZ_BYTE, 1'b1};
      OPC_LDH:  d = '{1'b1, 1'b0, SZ_HALF, 1'b1};
      OPC_LDW:  d = '{1'b1, 1'b0, SZ_WORD, 1'b0};
      OPC_LDBU: d = '{1'b1, 1'b0, SZ_BYTE, 1'b0};
      OPC_LDHU: d = '{1'b1, 1'b0, SZ_HALF, 1'b0};
      OPC_STB:  d = '{1'b0, 1'b1, SZ_BYTE, 1'b0};
      OPC_STH:  d = '{1'b0, 1'b1, SZ_HALF, 1'b0};
      OPC_STW:  d = '{1'b0, 1'b1, SZ_WORD, 1'b0};
      default:  ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [DATA_W-1:0] ea,
  output acc_dec_t          dec,
  output logic              mis
);
  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);

  logic [DATA_W-1:0] disp_ext;

  assign disp_ext = {{(DATA_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign ea       = base + disp_ext;
  assign dec      = decode_op(op);

  // Alignment rule: halfword needs bit 0 clear, word needs all lane bits clear.
  always_comb begin
    mis = 1'b0;
    if (dec.is_load || dec.is_store) begin
      case (dec.size)
        SZ_HALF: mis = ea[0];
        SZ_WORD: mis = |ea[LANE_BITS-1:0];
        default: mis = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                         en,
  input  acc_size_e                    size,
  input  logic [$clog2(DATA_W/8)-1:0]  off,
  input  logic [DATA_W-1:0]            src,
  output logic [DATA_W/8-1:0]          we,
  output logic [DATA_W-1:0]            lane_data
);
  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);

  logic [LANE_BITS:0]  nbytes;
  logic [DATA_W-1:0]   masked;
  logic [LANES-1:0]    hit;

  always_comb begin
    case (size)
      SZ_BYTE: nbytes = (LANE_BITS+1)'(1);
      SZ_HALF: nbytes = (LANE_BITS+1)'(2);
      default: nbytes = (LANE_BITS+1)'(LANES);
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // keep only the low bytes covered by the access size
    assign masked[8*i +: 8] = ((LANE_BITS+1)'(i) < nbytes) ? src[8*i +: 8] : 8'h00;
    // lane i is written when it lies in [off, off+nbytes)
    assign hit[i] = (LANE_BITS'(i) >= off) &&
                    (((LANE_BITS+1)'(i)) < ({1'b0, off} + nbytes));
    assign we[i]  = en && hit[i];
  end

  assign lane_data = en ? (masked << {off, 3'b000}) : '0;
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]           rdata,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  acc_size_e                   size,
  input  logic                        sext,
  output logic [DATA_W-1:0]           result
);
  logic [DATA_W-1:0] shifted;

  assign shifted = rdata >> {off, 3'b000};

  always_comb begin
    case (size)
      SZ_BYTE: result = {{(DATA_W-8){sext & shifted[7]}}, shifted[7:0]};
      SZ_HALF: result = {{(DATA_W-16){sext & shifted[15]}}, shifted[15:0]};
      default: result = shifted;
    endcase
  end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DISP_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [OP_W-1:0]     req_op,
  input  logic [DATA_W-1:0]   req_base,
  input  logic [DISP_W-1:0]   req_disp,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic [DATA_W-1:0]   mem_addr,
  output logic                mem_re,
  output logic [DATA_W/8-1:0] mem_we,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                misalign,
  output logic                ld_valid,
  input  logic                ld_ready,
  output logic [DATA_W-1:0]   ld_data
);
  localparam int LANE_BITS = $clog2(DATA_W/8);

  acc_dec_t            dec;
  logic                mis_raw;
  logic                take;
  logic                issue;
  logic                pend_q;
  logic [LANE_BITS-1:0] pend_off_q;
  acc_size_e           pend_size_q;
  logic                pend_sext_q;
  logic                res_valid_q;
  logic [DATA_W-1:0]   res_data_q;
  logic [DATA_W-1:0]   extracted;

  lsu_agen #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_agen (
    .op   (req_op),
    .base (req_base),
    .disp (req_disp),
    .ea   (mem_addr),
    .dec  (dec),
    .mis  (mis_raw)
  );

  assign req_ready = !pend_q && !(res_valid_q && !ld_ready);
  assign take      = req_valid && req_ready;
  assign issue     = take && !mis_raw;
  assign misalign  = take && mis_raw;
  assign mem_re    = issue && dec.is_load;

  lsu_store_lane #(.DATA_W(DATA_W)) u_store (
    .en        (issue && dec.is_store),
    .size      (dec.size),
    .off       (mem_addr[LANE_BITS-1:0]),
    .src       (req_wdata),
    .we        (mem_we),
    .lane_data (mem_wdata)
  );

  lsu_load_extract #(.DATA_W(DATA_W)) u_load (
    .rdata  (mem_rdata),
    .off    (pend_off_q),
    .size   (pend_size_q),
    .sext   (pend_sext_q),
    .result (extracted)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_off_q  <= '0;
      pend_size_q <= SZ_BYTE;
      pend_sext_q <= 1'b0;
    end else begin
      pend_q <= mem_re;
      if (mem_re) begin
        pend_off_q  <= mem_addr[LANE_BITS-1:0];
        pend_size_q <= dec.size;
        pend_sext_q <= dec.sext;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_data_q  <= '0;
    end else if (pend_q) begin
      res_valid_q <= 1'b1;
      res_data_q  <= extracted;
    end else if (ld_ready) begin
      res_valid_q <= 1'b0;
    end
  end

  assign ld_valid = res_valid_q;
  assign ld_data  = res_data_q;
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_ready,
  input logic                mem_re,
  input logic [DATA_W/8-1:0] mem_we,
  input logic                misalign,
  input logic                ld_valid,
  input logic                ld_ready,
  input logic [DATA_W-1:0]   ld_data
);
  // R3
  we_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mem_we) == 0) || ($countones(mem_we) == 1) ||
    ($countones(mem_we) == 2) || ($countones(mem_we) == DATA_W/8));

  // R9
  mis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_we == '0) && !mem_re);

  // R8
  load_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> ##1 ld_valid);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_ready) |=> ld_valid && $stable(ld_data));

  // R2
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (mem_we == '0) && !mem_re && !misalign);
endmodule

bind lsu_align_unit lsu_align_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .mem_re    (mem_re),
  .mem_we    (mem_we),
  .misalign  (misalign),
  .ld_valid  (ld_valid),
  .ld_ready  (ld_ready),
  .ld_data   (ld_data)
);

// File: tb/sim_lsu_align_unit.sv
`timescale 1ns/1ps
module sim_lsu_align_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_op = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_disp = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] mem_addr;
  logic        mem_re;
  logic [3:0]  mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        misalign;
  logic        ld_valid;
  logic        ld_ready = 1'b1;
  logic [31:0] ld_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] ram [16];
  logic [31:0] shadow [16];

  always #5 clk = ~clk;

  lsu_align_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_base(req_base), .req_disp(req_disp), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .misalign(misalign), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_data(ld_data)
  );

  // synchronous memory model, read data the cycle after mem_re
  always @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      if (mem_we[k]) ram[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
    if (mem_re) mem_rdata <= ram[mem_addr[5:2]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ea_of(input logic [31:0] b, input logic [15:0] d);
    return b + {{16{d[15]}}, d};
  endfunction

  function automatic int size_of(input logic [5:0] op);
    case (op)
      6'h20, 6'h24, 6'h28: return 1;
      6'h21, 6'h25, 6'h29: return 2;
      default:             return 4;
    endcase
  endfunction

  task automatic t_reset();
    chk("R2 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R2 reset ld_valid", {31'd0, ld_valid}, 32'd0);
    chk("R2 reset we", {28'd0, mem_we}, 32'd0);
  endtask

  task automatic t_store(input string req, input logic [5:0] op, input logic [31:0] b,
                         input logic [15:0] d, input logic [31:0] rt);
    logic [31:0] ea, exp_data, msk;
    logic [3:0]  exp_we;
    int nb, off;
    ea  = ea_of(b, d);
    nb  = size_of(op);
    off = int'(ea[1:0]);
    exp_we   = 4'(((1 << nb) - 1) << off);
    msk      = (nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*nb)) - 32'd1);
    exp_data = (rt & msk) << (8*off);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_base = b; req_disp = d; req_wdata = rt;
    #1;
    chk("R1 store address", mem_addr, ea);
    chk({req, " we"}, {28'd0, mem_we}, {28'd0, exp_we});
    chk({req, " wdata"}, mem_wdata, exp_data);
    @(posedge clk);
    for (int k = 0; k < 4; k++)
      if (exp_we[k]) shadow[ea[5:2]][8*k +: 8] = exp_data[8*k +: 8];
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_load(input string req, input logic [5:0] op, input logic [31:0] b,
                        input logic [15:0] d, input bit hold);
    logic [31:0] ea, w, exp_v;
    ea = ea_of(b, d);
    w  = shadow[ea[5:2]] >> (8 * int'(ea[1:0]));
    case (op)
      6'h20: exp_v = {{24{w[7]}}, w[7:0]};
      6'h21: exp_v = {{16{w[15]}}, w[15:0]};
      6'h24: exp_v = {24'd0, w[7:0]};
      6'h25: exp_v = {16'd0, w[15:0]};
      default: exp_v = w;
    endcase
    @(negedge clk);
    ld_ready = !hold;
    req_valid = 1'b1; req_op = op; req_base = b; req_disp = d;
    #1;
    chk("R1 load address", mem_addr, ea);
    chk("R8 read strobe", {31'd0, mem_re}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R2 ready low while in flight", {31'd0, req_ready}, 32'd0);
    chk("R8 not yet valid", {31'd0, ld_valid}, 32'd0);
    @(negedge clk);
    #1;
    chk("R8 valid after two cycles", {31'd0, ld_valid}, 32'd1);
    chk(req, ld_data, exp_v);
    if (hold) begin
      req_valid = 1'b1; req_op = 6'h2B; req_base = 32'h100; req_wdata = 32'hFFFF_FFFF;
      #1;
      chk("R2 ready low while held", {31'd0, req_ready}, 32'd0);
      chk("R2 no write while stalled", {28'd0, mem_we}, 32'd0);
      @(negedge clk);
      #1;
      chk("R8 held valid", {31'd0, ld_valid}, 32'd1);
      chk("R8 held data", ld_data, exp_v);
      req_valid = 1'b0;
      ld_ready  = 1'b1;
    end
    @(negedge clk);
    #1;
    chk("R8 consumed", {31'd0, ld_valid}, 32'd0);
    chk("R2 ready again", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_quiet(input string req, input logic [5:0] op, input logic [31:0] b,
                         input logic [15:0] d, input bit exp_mis);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_base = b; req_disp = d; req_wdata = 32'h5A5A_5A5A;
    #1;
    chk({req, " flag"}, {31'd0, misalign}, {31'd0, exp_mis});
    chk({req, " no write"}, {28'd0, mem_we}, 32'd0);
    chk({req, " no read"}, {31'd0, mem_re}, 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    #1;
    chk({req, " no result"}, {31'd0, ld_valid}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 16; k++) begin ram[k] = '0; shadow[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_store("R5 word store", 6'h2B, 32'h100, 16'h0000, 32'h8899_AABB);
    t_store("R5 word store neg disp", 6'h2B, 32'h120, 16'hFFE4, 32'h1122_3344);
    t_store("R3 byte store lane1", 6'h28, 32'h100, 16'h0005, 32'hDEAD_BEF1);
    t_store("R3 byte store lane3", 6'h28, 32'h100, 16'h0003, 32'h0000_007F);
    t_store("R4 half store upper", 6'h29, 32'h100, 16'h000A, 32'hCAFE_807E);
    t_store("R4 half store lower", 6'h29, 32'h110, 16'hFFFC, 32'h1234_C001);
    t_load("R6 signed byte", 6'h20, 32'h100, 16'h0001, 1'b0);
    t_load("R7 unsigned byte", 6'h24, 32'h100, 16'h0001, 1'b0);
    t_load("R6 signed byte positive", 6'h20, 32'h100, 16'h0003, 1'b0);
    t_load("R6 signed half", 6'h21, 32'h100, 16'h000A, 1'b0);
    t_load("R7 unsigned half", 6'h25, 32'h100, 16'h000A, 1'b0);
    t_load("R6 signed half low", 6'h21, 32'h100, 16'h0000, 1'b0);
    t_load("R7 unsigned half upper", 6'h25, 32'h100, 16'h0006, 1'b0);
    t_load("R6 word load", 6'h23, 32'h200, 16'hFF04, 1'b0);
    t_load("R6 signed byte lane1 held", 6'h20, 32'h100, 16'h0005, 1'b1);
    t_load("R6 half load lower lanes", 6'h21, 32'h100, 16'h000C, 1'b0);
    t_quiet("R9 misaligned word store", 6'h2B, 32'h100, 16'h0002, 1'b1);
    t_quiet("R9 misaligned half store", 6'h29, 32'h100, 16'h0001, 1'b1);
    t_quiet("R9 misaligned word load", 6'h23, 32'h100, 16'h0001, 1'b1);
    t_quiet("R9 misaligned half load", 6'h25, 32'h100, 16'h0003, 1'b1);
    t_quiet("R10 unknown opcode 0x22", 6'h22, 32'h100, 16'h0000, 1'b0);
    t_quiet("R10 unknown opcode 0x00", 6'h00, 32'h104, 16'h0000, 1'b0);
    t_load("R9 word untouched by misaligned store", 6'h23, 32'h100, 16'h0000, 1'b0);
    t_load("R9 half word untouched", 6'h23, 32'h100, 16'h0000, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule